// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block is an up-counting timer with a word-addressed register port. Software picks a tick source (a peripheral-rate tick or a slow 32 kHz tick, both given as one-cycle enable inputs), sets a 12-bit divider, and starts the counter. The counter can run freely up to all ones and wrap, or, in restart mode, fall back to zero after it matches the first compare value. Three compare registers raise their own status flags, a wrap raises a rollover flag, and a level interrupt is driven from the flags that software has enabled. Software clears flags by writing ones.

The register port is a plain single-cycle strobe: a write is taken on any clock edge where `bus_sel` and `bus_wr` are both high, and `bus_rdata` shows the register picked by `bus_addr` in the same cycle. There is no back-pressure. The port never stalls, and a read has no side effects. The counter width is a parameter (`CNT_W`, default 32). The compare registers and the counter readback use that width and are zero-extended to 32 bits on read.

Word offsets: 0 control, 1 divider, 2 status, 3 interrupt enable, 4/5/6 compare channels 1/2/3, 7/8 capture (always zero), 9 counter.

Top module: `cmp3_timer`

## Requirements
- R1: After hardware reset, control, divider, status, interrupt enable and counter read 0, and all three compare registers read all ones (CNT_W bits). Offsets 7, 8 and 10 to 15 always read 0, and writes to them change nothing.
- R2: A control write always stores bits 2, 4 and 10 to 14 as 0. All other bits read back as written. Bit 0 is enable, bit 1 is enable mode, bits 8:6 select the source, bit 9 chooses free-run (1) or restart (0), and bit 15 is soft reset.
- R3: Source codes 001 and 010 count `tick_pclk`, code 100 counts `tick_slow`, and every other code gives no count.
- R4: The divider register keeps only its low 12 bits. The counter advances once every (divider + 1) selected source ticks while enabled.
- R5: When the counter steps from all ones to 0, status bit 5 (rollover) is set.
- R6: Status bit k (k = 0, 1, 2) is set on the step that brings the counter to the value of compare channel k+1.
- R7: A status write clears each of bits 5:0 that is written as 1 and leaves the others unchanged. If a flag is set in the same cycle as it is cleared, the set wins.
- R8: `irq` is high exactly when enable is 1 and (status AND interrupt enable) is nonzero. Interrupt-enable bits use the status bit positions.
- R9: In restart mode, the step after the counter matches compare channel 1 returns the counter to 0.
- R10: A write to compare channel 1 in restart mode zeroes the counter. In free-run mode the same write leaves the counter alone.
- R11: Writing control with bit 15 set clears control bits 5:0 and zeroes status, divider, interrupt enable and counter. It sets all compare registers to all ones. Bit 15 reads 1 for one cycle and then clears itself.
- R12: When enable goes from 0 to 1 with enable mode 1, the counter restarts from 0. With enable mode 0 it resumes from its held value. While enable is 0 the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for `bus_sel` |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| tick_pclk | input | 1 | Peripheral-rate tick enable |
| tick_slow | input | 1 | 32 kHz tick enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the timer with a 10-bit counter so that it can reach the wrap. There, all three compare registers still hold their all-ones reset value, so a design that flags compares only on a change of compare value, or that misses the rollover flag, shows the wrong status pattern. It checks the restart return to zero and the compare-1 write that clears the count in restart mode but not in free-run mode. A design that confuses the two modes leaves a nonzero count. Resume against restart on enable, the divider period, and the gating of the source codes are each checked by counting exact ticks. An off-by-one in the divider or a source decoded from the wrong code gives a count that is visibly wrong. The soft-reset check reads control both on the cycle of the write and on the cycle after, to catch a reset bit that sticks.

// File: rtl/cmp3_timer_pkg.sv
package cmp3_timer_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int NCMP    = 3;
  localparam int STAT_W  = 6;
  localparam int SRC_W   = 3;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_DIV   = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 4'd3;
  localparam logic [ADDR_W-1:0] OFF_CMP0  = 4'd4;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 4'd9;

  localparam int B_EN    = 0;
  localparam int B_ENMOD = 1;
  localparam int B_SRC   = 6;
  localparam int B_FREE  = 9;
  localparam int B_SWR   = 15;
  localparam int ST_ROLL = 5;

  localparam logic [DATA_W-1:0] CTRL_ZERO_MASK = 32'h0000_7C14;
  localparam logic [DATA_W-1:0] CTRL_SWR_CLR   = 32'h0000_003F;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'b000,
    SRC_PCLK = 3'b001,
    SRC_PCLK_HF = 3'b010,
    SRC_SLOW = 3'b100
  } src_sel_e;
endpackage

// File: rtl/cmp3_tick_gen.sv
module cmp3_tick_gen
  import cmp3_timer_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             tick_pclk,
  input  logic             tick_slow,
  output logic             adv
);
  logic             src_tick;
  logic [DIV_W-1:0] div_q;

  always_comb begin
    case (src_sel)
      SRC_PCLK, SRC_PCLK_HF: src_tick = tick_pclk;
      SRC_SLOW:              src_tick = tick_slow;
      default:               src_tick = 1'b0;
    endcase
  end

  assign adv = run && src_tick && (div_q >= div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (clr)              div_q <= '0;
    else if (run && src_tick)  div_q <= (div_q >= div_val) ? '0 : div_q + DIV_W'(1);
  end

  // R4: with a nonzero divider two steps are never back to back
  p_div_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (!adv || div_val == '0));
endmodule

// File: rtl/cmp3_counter.sv
module cmp3_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             restart_mode,
  input  logic [CNT_W-1:0] wrap_at,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next,
  output logic             wrapped
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_next = (restart_mode && cnt_q == wrap_at) ? '0 : cnt_q + CNT_W'(1);
  assign wrapped  = adv && !clr && (cnt_q == '1);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_next;
  end

  // R12: without a step or clear the count holds
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt_q));
  // R9: restart mode returns to zero after the channel-1 match
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && restart_mode && cnt_q == wrap_at) |=> (cnt_q == '0));
endmodule

// File: rtl/cmp3_match.sv
module cmp3_match
  import cmp3_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                       step,
  input  logic [CNT_W-1:0]           cnt_next,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp,
  output logic [NCMP-1:0]            hit
);
  for (genvar k = 0; k < NCMP; k++) begin : g_ch
    assign hit[k] = step && (cnt_next == cmp[k]);
  end
endmodule

// File: rtl/cmp3_timer.sv
module cmp3_timer
  import cmp3_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_pclk,
  input  logic              tick_slow,
  output logic              irq
);
  logic [DATA_W-1:0]          ctrl_q, ctrl_new;
  logic [DIV_W-1:0]           div_q;
  logic [STAT_W-1:0]          stat_q, ien_q, stat_set, stat_clr;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [NCMP-1:0]            wr_cmp, hit;
  logic [CNT_W-1:0]           cnt, cnt_next;
  logic wr_any, wr_ctrl, wr_div, wr_stat, wr_ien;
  logic swr, en_restart, cmp_restart, cnt_clr, adv, wrapped;

  assign wr_any  = bus_sel && bus_wr;
  assign wr_ctrl = wr_any && bus_addr == OFF_CTRL;
  assign wr_div  = wr_any && bus_addr == OFF_DIV;
  assign wr_stat = wr_any && bus_addr == OFF_STAT;
  assign wr_ien  = wr_any && bus_addr == OFF_IEN;
  for (genvar k = 0; k < NCMP; k++) begin : g_wsel
    assign wr_cmp[k] = wr_any && bus_addr == OFF_CMP0 + ADDR_W'(k);
  end

  assign ctrl_new    = bus_wdata & ~CTRL_ZERO_MASK;
  assign swr         = wr_ctrl && ctrl_new[B_SWR];
  assign en_restart  = wr_ctrl && !swr && !ctrl_q[B_EN] && ctrl_new[B_EN] && ctrl_new[B_ENMOD];
  assign cmp_restart = wr_cmp[0] && !ctrl_q[B_FREE];
  assign cnt_clr     = swr || en_restart || cmp_restart;

  cmp3_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(ctrl_q[B_EN]),
    .src_sel(ctrl_q[B_SRC +: SRC_W]), .div_val(div_q),
    .tick_pclk(tick_pclk), .tick_slow(tick_slow), .adv(adv)
  );

  cmp3_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(adv),
    .restart_mode(!ctrl_q[B_FREE]), .wrap_at(cmp_q[0]),
    .cnt(cnt), .cnt_next(cnt_next), .wrapped(wrapped)
  );

  cmp3_match #(.CNT_W(CNT_W)) u_match (
    .step(adv && !cnt_clr), .cnt_next(cnt_next), .cmp(cmp_q), .hit(hit)
  );

  always_comb begin
    stat_set = '0;
    stat_set[NCMP-1:0] = hit;
    stat_set[ST_ROLL]  = wrapped;
    stat_clr = wr_stat ? bus_wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      cmp_q  <= '1;
    end else begin
      if (wr_ctrl)            ctrl_q <= swr ? (ctrl_new & ~CTRL_SWR_CLR) : ctrl_new;
      else if (ctrl_q[B_SWR]) ctrl_q[B_SWR] <= 1'b0;
      if (swr) begin
        div_q  <= '0;
        stat_q <= '0;
        ien_q  <= '0;
        cmp_q  <= '1;
      end else begin
        if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
        if (wr_ien) ien_q <= bus_wdata[STAT_W-1:0];
        stat_q <= (stat_q & ~stat_clr) | stat_set;
        for (int k = 0; k < NCMP; k++)
          if (wr_cmp[k]) cmp_q[k] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL:  bus_rdata = ctrl_q;
      OFF_DIV:   bus_rdata = DATA_W'(div_q);
      OFF_STAT:  bus_rdata = DATA_W'(stat_q);
      OFF_IEN:   bus_rdata = DATA_W'(ien_q);
      OFF_COUNT: bus_rdata = DATA_W'(cnt);
      default: begin
        for (int k = 0; k < NCMP; k++)
          if (bus_addr == OFF_CMP0 + ADDR_W'(k)) bus_rdata = DATA_W'(cmp_q[k]);
      end
    endcase
  end

  assign irq = ctrl_q[B_EN] && |(stat_q & ien_q);

  // R11: the soft-reset bit clears itself on the next edge
  p_swr_self_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_SWR] && !wr_ctrl) |=> !ctrl_q[B_SWR]);
  // R5: a fresh rollover flag always coincides with a zero count
  p_roll_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_ROLL]) |-> (cnt == '0));
  for (genvar k = 0; k < NCMP; k++) begin : g_chk
    // R6: a fresh compare flag means the count sits on that compare value
    p_cmp_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat_q[k]) && $stable(cmp_q[k])) |-> (cnt == cmp_q[k]));
  end
endmodule

// File: tb/cmp3_timer_tb.sv
`timescale 1ns/1ps
module cmp3_timer_tb;
  localparam int CW = 10;
  localparam logic [31:0] CMAX = 32'h3FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, tick_pclk = 0, tick_slow = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, failures = 0;

  cmp3_timer #(.CNT_W(CW), .DIV_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_pclk(tick_pclk), .tick_slow(tick_slow), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    #1; chk(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic pulse(input int n, input logic p, input logic s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_pclk = p; tick_slow = s;
      @(negedge clk); tick_pclk = 0; tick_slow = 0;
    end
  endtask

  task automatic start(input logic [2:0] src, input logic free, input logic [31:0] dv);
    wr(0, 32'h8000);
    wr(1, dv);
    wr(0, 32'h3 | (32'(free) << 9) | (32'(src) << 6));
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 0, 0);    rd_chk("R1 div", 1, 0);
    rd_chk("R1 stat", 2, 0);    rd_chk("R1 ien", 3, 0);
    rd_chk("R1 cmp1", 4, CMAX); rd_chk("R1 cmp2", 5, CMAX);
    rd_chk("R1 cmp3", 6, CMAX); rd_chk("R1 cap1", 7, 0);
    rd_chk("R1 cap2", 8, 0);    rd_chk("R1 count", 9, 0);
    irq_chk("R1 irq", 0);
    wr(7, 32'hFFFF); rd_chk("R1 cap write ignored", 7, 0);
    wr(12, 32'h1234); rd_chk("R1 unmapped read", 12, 0);
    rd_chk("R1 ctrl untouched", 0, 0);
  endtask

  task automatic t_ctrl_mask;
    wr(0, 32'hFFFF_7FFF);
    rd_chk("R2 ctrl mask", 0, 32'hFFFF_03EB);
    wr(0, 32'h8000);
  endtask

  task automatic t_clock_src;
    start(3'b001, 1, 0); pulse(3, 1, 0); rd_chk("R3 src1 pclk", 9, 3);
    pulse(2, 0, 1); rd_chk("R3 src1 ignores slow", 9, 3);
    start(3'b010, 1, 0); pulse(2, 1, 0); rd_chk("R3 src2 pclk", 9, 2);
    start(3'b100, 1, 0); pulse(3, 0, 1); rd_chk("R3 src4 slow", 9, 3);
    pulse(2, 1, 0); rd_chk("R3 src4 ignores pclk", 9, 3);
    start(3'b011, 1, 0); pulse(2, 1, 1); rd_chk("R3 src3 none", 9, 0);
    start(3'b000, 1, 0); pulse(2, 1, 1); rd_chk("R3 src0 none", 9, 0);
  endtask

  task automatic t_prescale;
    start(3'b001, 1, 2);
    pulse(2, 1, 0); rd_chk("R4 div2 before step", 9, 0);
    pulse(1, 1, 0); rd_chk("R4 div2 first step", 9, 1);
    pulse(3, 1, 0); rd_chk("R4 div2 second step", 9, 2);
    wr(1, 32'h000F_FFFF); rd_chk("R4 div 12 bits", 1, 32'hFFF);
  endtask

  task automatic t_wrap;
    start(3'b001, 1, 0); wr(3, 32'h20);
    pulse(1023, 1, 0);
    rd_chk("R5 count at top", 9, CMAX);
    rd_chk("R6 all cmp hit at top", 2, 32'h07);
    irq_chk("R8 irq masked", 0);
    pulse(1, 1, 0);
    rd_chk("R5 wrap to zero", 9, 0);
    rd_chk("R5 rollover flag", 2, 32'h27);
    irq_chk("R8 irq on rollover", 1);
  endtask

  task automatic t_compare;
    start(3'b001, 1, 0); wr(5, 5);
    pulse(4, 1, 0); rd_chk("R6 no early flag", 2, 0);
    pulse(1, 1, 0); rd_chk("R6 cmp2 flag", 2, 32'h02);
    rd_chk("R6 count at match", 9, 5);
    irq_chk("R8 irq not enabled", 0);
    wr(3, 32'h02); irq_chk("R8 irq enabled", 1);
    wr(2, 32'h01); rd_chk("R7 other bit kept", 2, 32'h02);
    wr(0, 32'h242); irq_chk("R8 irq gated by enable", 0);
    wr(0, 32'h241); irq_chk("R8 irq back", 1);
    wr(2, 32'h02); rd_chk("R7 w1c", 2, 0);
    irq_chk("R8 irq after clear", 0);
    wr(4, 2); rd_chk("R10 free-run cmp1 write keeps count", 9, 5);
  endtask

  task automatic t_restart;
    start(3'b001, 0, 0); pulse(2, 1, 0);
    wr(4, 3); rd_chk("R10 cmp1 write zeroes", 9, 0);
    pulse(3, 1, 0); rd_chk("R9 reach cmp1", 9, 3);
    rd_chk("R6 cmp1 flag", 2, 32'h01);
    pulse(1, 1, 0); rd_chk("R9 back to zero", 9, 0);
    pulse(2, 1, 0); rd_chk("R9 counts again", 9, 2);
    wr(4, 7); rd_chk("R10 second cmp1 write", 9, 0);
  endtask

  task automatic t_soft_reset;
    start(3'b001, 1, 0); wr(6, 1);
    pulse(1, 1, 0); rd_chk("R11 pre stat", 2, 32'h04);
    wr(1, 5); wr(3, 32'h3F); irq_chk("R11 pre irq", 1);
    wr(0, 32'h0000_823F);
    rd_chk("R11 swr visible", 0, 32'h8200);
    @(negedge clk);
    rd_chk("R11 swr cleared", 0, 32'h200);
    rd_chk("R11 div", 1, 0); rd_chk("R11 stat", 2, 0);
    rd_chk("R11 ien", 3, 0); rd_chk("R11 cmp3", 6, CMAX);
    rd_chk("R11 count", 9, 0); irq_chk("R11 irq", 0);
    pulse(2, 1, 0); rd_chk("R11 stopped", 9, 0);
  endtask

  task automatic t_enable_mode;
    start(3'b001, 1, 0); pulse(4, 1, 0); rd_chk("R12 run", 9, 4);
    wr(0, 32'h242); pulse(2, 1, 0); rd_chk("R12 frozen", 9, 4);
    wr(0, 32'h241); pulse(1, 1, 0); rd_chk("R12 resume", 9, 5);
    wr(0, 32'h240); wr(0, 32'h243); rd_chk("R12 restart zero", 9, 0);
    pulse(1, 1, 0); rd_chk("R12 after restart", 9, 1);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl_mask();
    t_clock_src();
    t_prescale();
    t_wrap();
    t_compare();
    t_restart();
    t_soft_reset();
    t_enable_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule